// File: doc/BRIEF.md
# External Interrupt Controller (single target)

This block collects level requests from 80 peripheral sources and turns them into one external-interrupt line for a single hart. Each source has a sticky pending bit, an enable bit and a 3-bit priority. A global 2-bit threshold masks the low-priority sources. The line is raised whenever a pending, enabled source has a priority strictly above the threshold.

Software uses a 32-bit register port with a fixed word map inside a 1 KiB window. It reads the claim register to learn which source to service. That read also drops the source's pending bit. Writing the same ID back completes the interrupt. A two-state machine tracks the claim. In `CLM_IDLE` no claim is held. The transition `capture` (IDLE→HELD) fires on the first edge at which an eligible source exists, and latches the lowest-numbered eligible ID. In `CLM_HELD` the ID is frozen. The transition `complete` (HELD→IDLE) fires on a write to the claim register whose data equals the held ID.

Top module: `ext_irq_ctrl`

## Requirements
- R1: A high level on `src_i[n]` (n ≥ 1) sets pending bit n at the next edge. The bit stays set after the source drops, until a claim read clears it. Source 0 never becomes pending. Pending words sit at word offsets 0x000, 0x004 and 0x008. Source n is at word n/32, bit n%32.
- R2: The pending words are read-only, and writes to them change nothing. The three trigger-mode words at 0x00C–0x014 always read zero and ignore writes.
- R3: Priority word k lives at 0x018 + 4·k for k in 0..79. Reading word k returns the priority of source k in bits [2:0]. Writing word k stores wdata[2:0] as the priority of source k+1. A write to word 79 has no target and is ignored.
- R4: The enable words at 0x200–0x208 use the same bit layout as the pending words. They can be read and written. Bits that name no source (80 and up) read zero.
- R5: The threshold at 0x20C keeps only wdata[1:0].
- R6: `irq_o` is high exactly when some source n ≥ 1 is pending and enabled and has a priority strictly greater than the threshold. It follows the registered state in the same cycle, with no extra delay.
- R7: In `CLM_IDLE`, if an eligible source exists at an edge, that edge moves to `CLM_HELD` and captures the lowest-numbered eligible ID. In `CLM_HELD` the ID is not replaced, even when other sources become eligible.
- R8: A read of 0x210 returns the held ID, or 0 when idle. At the same edge it clears that source's pending bit, unless the source is still driving high in that cycle.
- R9: A write to 0x210 whose full 32-bit data equals the held ID returns the claim to 0 (`CLM_IDLE`). Any other value is ignored.
- R10: `rdata_o` carries the read value in the cycle after `rd_en_i`. It is zero in every cycle that follows no read. Unmapped or misaligned addresses read zero, and writes to them have no effect.
- R11: After reset every stored field is zero, `irq_o` is low and the claim is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | 80 | Level requests, one per source |
| addr_i | input | 10 | Byte address inside the register window |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | External interrupt request to the hart |

## Verification
Source levels, register writes and claim reads all take effect at the first rising edge that samples them. `irq_o` reflects the new state right after that edge, the captured claim ID appears one edge later, and read data arrives one edge after the strobe. The bench drives its inputs at falling edges and advances its behavioural model at the rising edge. It then compares `irq_o` and `rdata_o` with the model at the following falling edge in every cycle, so each result is checked in exactly the cycle it is due.

// File: rtl/eic_pkg.sv
`timescale 1ns/1ps
package eic_pkg;
    localparam int unsigned WORD_BITS  = 32;
    // word-index bases of the fixed map
    localparam int unsigned PEND_WBASE = 0;    // 0x000
    localparam int unsigned MODE_WBASE = 3;    // 0x00C
    localparam int unsigned PRIO_WBASE = 6;    // 0x018
    localparam int unsigned EN_WBASE   = 128;  // 0x200
    localparam int unsigned THR_WIDX   = 131;  // 0x20C
    localparam int unsigned CLM_WIDX   = 132;  // 0x210

    typedef enum logic [0:0] {
        CLM_IDLE = 1'b0,
        CLM_HELD = 1'b1
    } clm_state_e;

    typedef enum logic [2:0] {
        RG_NONE = 3'd0,
        RG_PEND = 3'd1,
        RG_MODE = 3'd2,
        RG_PRIO = 3'd3,
        RG_EN   = 3'd4,
        RG_THR  = 3'd5,
        RG_CLM  = 3'd6
    } region_e;
endpackage

// File: rtl/eic_decode.sv
`timescale 1ns/1ps
module eic_decode
    import eic_pkg::*;
#(
    parameter int unsigned NUM_SRC = 80,
    parameter int unsigned ADDR_W  = 10,
    parameter int unsigned IDX_W   = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    output region_e           region_o,
    output logic [IDX_W-1:0]  off_o
);
    localparam int unsigned NUM_WORDS = (NUM_SRC + WORD_BITS - 1) / WORD_BITS;

    logic [31:0] widx;
    logic [31:0] o_pend, o_mode, o_prio, o_en;

    assign widx   = 32'(addr_i[ADDR_W-1:2]);
    assign o_pend = widx - PEND_WBASE;
    assign o_mode = widx - MODE_WBASE;
    assign o_prio = widx - PRIO_WBASE;
    assign o_en   = widx - EN_WBASE;

    always_comb begin
        region_o = RG_NONE;
        off_o    = '0;
        if (addr_i[1:0] != 2'b00) begin
            region_o = RG_NONE;
        end else if (o_pend < NUM_WORDS) begin
            region_o = RG_PEND;
            off_o    = IDX_W'(o_pend);
        end else if (o_mode < NUM_WORDS) begin
            region_o = RG_MODE;
            off_o    = IDX_W'(o_mode);
        end else if (o_prio < NUM_SRC) begin
            region_o = RG_PRIO;
            off_o    = IDX_W'(o_prio);
        end else if (o_en < NUM_WORDS) begin
            region_o = RG_EN;
            off_o    = IDX_W'(o_en);
        end else if (widx == THR_WIDX) begin
            region_o = RG_THR;
        end else if (widx == CLM_WIDX) begin
            region_o = RG_CLM;
        end
    end
endmodule

// File: rtl/eic_regs.sv
`timescale 1ns/1ps
module eic_regs
    import eic_pkg::*;
#(
    parameter int unsigned NUM_SRC = 80,
    parameter int unsigned PRIO_W  = 3,
    parameter int unsigned THR_W   = 2,
    parameter int unsigned IDX_W   = 8,
    parameter int unsigned ID_W    = 7
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic [NUM_SRC-1:0]             src_i,
    input  logic                           wr_en_i,
    input  logic                           rd_en_i,
    input  region_e                        region_i,
    input  logic [IDX_W-1:0]               off_i,
    input  logic [31:0]                    wdata_i,
    input  logic [ID_W-1:0]                claim_id_i,
    output logic [NUM_SRC-1:0]             pend_o,
    output logic [NUM_SRC-1:0]             en_o,
    output logic [NUM_SRC-1:0][PRIO_W-1:0] prio_o,
    output logic [THR_W-1:0]               thr_o,
    output logic [31:0]                    rval_o
);
    localparam int unsigned NUM_WORDS = (NUM_SRC + WORD_BITS - 1) / WORD_BITS;
    localparam int unsigned PAD_BITS  = NUM_WORDS * WORD_BITS;

    logic clm_rd;
    logic wr_prio, wr_en_reg, wr_thr;
    logic [THR_W-1:0] thr_q;

    assign clm_rd    = rd_en_i && (region_i == RG_CLM);
    assign wr_prio   = wr_en_i && (region_i == RG_PRIO);
    assign wr_en_reg = wr_en_i && (region_i == RG_EN);
    assign wr_thr    = wr_en_i && (region_i == RG_THR);

    // per-source storage: pending, enable, priority
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        if (s == 0) begin : g_zero
            logic en0_q;
            assign pend_o[s] = 1'b0;
            assign prio_o[s] = '0;
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni)
                    en0_q <= 1'b0;
                else if (wr_en_reg && off_i == IDX_W'(0))
                    en0_q <= wdata_i[0];
            end
            assign en_o[s] = en0_q;
        end else begin : g_live
            logic pend_q, en_q;
            logic [PRIO_W-1:0] prio_q;
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    pend_q <= 1'b0;
                end else if (src_i[s]) begin
                    pend_q <= 1'b1;
                end else if (clm_rd && claim_id_i == ID_W'(s)) begin
                    pend_q <= 1'b0;
                end
            end
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni)
                    en_q <= 1'b0;
                else if (wr_en_reg && off_i == IDX_W'(s / WORD_BITS))
                    en_q <= wdata_i[s % WORD_BITS];
            end
            // word k programs source k+1
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni)
                    prio_q <= '0;
                else if (wr_prio && off_i == IDX_W'(s - 1))
                    prio_q <= wdata_i[PRIO_W-1:0];
            end
            assign pend_o[s] = pend_q;
            assign en_o[s]   = en_q;
            assign prio_o[s] = prio_q;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            thr_q <= '0;
        else if (wr_thr)
            thr_q <= wdata_i[THR_W-1:0];
    end
    assign thr_o = thr_q;

    // read path: OR-chains over words and priority entries
    logic [PAD_BITS-1:0] pend_pad, en_pad;
    logic [31:0] pend_acc [NUM_WORDS+1];
    logic [31:0] en_acc   [NUM_WORDS+1];
    logic [31:0] prio_acc [NUM_SRC+1];

    assign pend_pad    = PAD_BITS'(pend_o);
    assign en_pad      = PAD_BITS'(en_o);
    assign pend_acc[0] = '0;
    assign en_acc[0]   = '0;
    assign prio_acc[0] = '0;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic hit;
        assign hit = (off_i == IDX_W'(w));
        assign pend_acc[w+1] = pend_acc[w] |
                               (hit ? pend_pad[w*WORD_BITS +: WORD_BITS] : 32'd0);
        assign en_acc[w+1]   = en_acc[w] |
                               (hit ? en_pad[w*WORD_BITS +: WORD_BITS] : 32'd0);
    end

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_prd
        assign prio_acc[k+1] = prio_acc[k] |
                               ((off_i == IDX_W'(k)) ? 32'(prio_o[k]) : 32'd0);
    end

    always_comb begin
        rval_o = '0;
        unique case (region_i)
            RG_PEND: rval_o = pend_acc[NUM_WORDS];
            RG_MODE: rval_o = '0;
            RG_PRIO: rval_o = prio_acc[NUM_SRC];
            RG_EN:   rval_o = en_acc[NUM_WORDS];
            RG_THR:  rval_o = 32'(thr_q);
            RG_CLM:  rval_o = 32'(claim_id_i);
            default: rval_o = '0;
        endcase
    end
endmodule

// File: rtl/eic_select.sv
`timescale 1ns/1ps
module eic_select #(
    parameter int unsigned NUM_SRC = 80,
    parameter int unsigned PRIO_W  = 3,
    parameter int unsigned THR_W   = 2,
    parameter int unsigned ID_W    = 7
) (
    input  logic [NUM_SRC-1:0]             pend_i,
    input  logic [NUM_SRC-1:0]             en_i,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
    input  logic [THR_W-1:0]               thr_i,
    output logic                           any_o,
    output logic [ID_W-1:0]                sel_id_o
);
    logic [NUM_SRC-1:0] elig;
    logic [ID_W-1:0]    pick [NUM_SRC+1];

    assign pick[NUM_SRC] = '0;

    // lowest eligible index wins: chain runs from the top index down
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_elig
        if (n == 0) begin : g_none
            assign elig[n] = 1'b0;
        end else begin : g_cmp
            assign elig[n] = pend_i[n] & en_i[n] & (prio_i[n] > PRIO_W'(thr_i));
        end
        assign pick[n] = elig[n] ? ID_W'(n) : pick[n+1];
    end

    assign any_o    = |elig;
    assign sel_id_o = pick[0];
endmodule

// File: rtl/eic_claim_fsm.sv
`timescale 1ns/1ps
module eic_claim_fsm
    import eic_pkg::*;
#(
    parameter int unsigned ID_W = 7
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            any_i,
    input  logic [ID_W-1:0] sel_id_i,
    input  logic            cmp_wr_i,
    input  logic [31:0]     wdata_i,
    output logic [ID_W-1:0] claim_id_o
);
    clm_state_e      state_q, state_d;
    logic [ID_W-1:0] id_q, id_d;

    always_comb begin
        state_d = state_q;
        id_d    = id_q;
        unique case (state_q)
            CLM_IDLE: begin
                if (any_i) begin           // capture
                    state_d = CLM_HELD;
                    id_d    = sel_id_i;
                end
            end
            CLM_HELD: begin
                if (cmp_wr_i && wdata_i == 32'(id_q)) begin   // complete
                    state_d = CLM_IDLE;
                    id_d    = '0;
                end
            end
            default: begin
                state_d = CLM_IDLE;
                id_d    = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= CLM_IDLE;
            id_q    <= '0;
        end else begin
            state_q <= state_d;
            id_q    <= id_d;
        end
    end

    always_comb begin
        claim_id_o = '0;
        unique case (state_q)
            CLM_IDLE: claim_id_o = '0;
            CLM_HELD: claim_id_o = id_q;
            default:  claim_id_o = '0;
        endcase
    end
endmodule

// File: rtl/ext_irq_ctrl.sv
`timescale 1ns/1ps
module ext_irq_ctrl
    import eic_pkg::*;
#(
    parameter int unsigned NUM_SRC = 80,
    parameter int unsigned PRIO_W  = 3,
    parameter int unsigned THR_W   = 2,
    parameter int unsigned ADDR_W  = 10
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               wr_en_i,
    input  logic [31:0]        wdata_i,
    input  logic               rd_en_i,
    output logic [31:0]        rdata_o,
    output logic               irq_o
);
    localparam int unsigned IDX_W = ADDR_W - 2;
    localparam int unsigned ID_W  = $clog2(NUM_SRC);

    region_e                    region;
    logic [IDX_W-1:0]           off;
    logic [NUM_SRC-1:0]         pend_w, en_w;
    logic [NUM_SRC-1:0][PRIO_W-1:0] prio_w;
    logic [THR_W-1:0]           thr_w;
    logic [31:0]                rval;
    logic                       any_elig;
    logic [ID_W-1:0]            sel_id, claim_id_w;
    logic                       cmp_wr;
    logic [31:0]                rdata_q;

    eic_decode #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
        .addr_i   (addr_i),
        .region_o (region),
        .off_o    (off)
    );

    eic_regs #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .THR_W(THR_W),
               .IDX_W(IDX_W), .ID_W(ID_W)) u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .src_i      (src_i),
        .wr_en_i    (wr_en_i),
        .rd_en_i    (rd_en_i),
        .region_i   (region),
        .off_i      (off),
        .wdata_i    (wdata_i),
        .claim_id_i (claim_id_w),
        .pend_o     (pend_w),
        .en_o       (en_w),
        .prio_o     (prio_w),
        .thr_o      (thr_w),
        .rval_o     (rval)
    );

    eic_select #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .THR_W(THR_W), .ID_W(ID_W)) u_sel (
        .pend_i   (pend_w),
        .en_i     (en_w),
        .prio_i   (prio_w),
        .thr_i    (thr_w),
        .any_o    (any_elig),
        .sel_id_o (sel_id)
    );

    assign cmp_wr = wr_en_i && (region == RG_CLM);

    eic_claim_fsm #(.ID_W(ID_W)) u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .any_i      (any_elig),
        .sel_id_i   (sel_id),
        .cmp_wr_i   (cmp_wr),
        .wdata_i    (wdata_i),
        .claim_id_o (claim_id_w)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            rdata_q <= '0;
        else
            rdata_q <= rd_en_i ? rval : 32'd0;
    end

    assign rdata_o = rdata_q;
    assign irq_o   = any_elig;
endmodule

// File: rtl/eic_checker.sv
`timescale 1ns/1ps
module eic_checker #(
    parameter int unsigned NUM_SRC = 80,
    parameter int unsigned ADDR_W  = 10,
    parameter int unsigned ID_W    = 7
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [NUM_SRC-1:0] src_i,
    input logic [ADDR_W-1:0]  addr_i,
    input logic               wr_en_i,
    input logic               rd_en_i,
    input logic [31:0]        wdata_i,
    input logic [31:0]        rdata_o,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] pend,
    input logic [NUM_SRC-1:0] en,
    input logic [ID_W-1:0]    claim_id
);
    logic at_claim, clm_rd, cmp_match;
    assign at_claim  = (addr_i == ADDR_W'(12'h210));
    assign clm_rd    = rd_en_i && at_claim;
    assign cmp_match = wr_en_i && at_claim && (wdata_i == 32'(claim_id));

    p_src_sets_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src_i != '0) |=> (($past(src_i) & ~pend & ~NUM_SRC'(1)) == '0));

    p_pend_sticky_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clm_rd |=> (($past(pend) & ~pend) == '0));

    p_irq_needs_pend_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> ((pend & en) != '0));

    p_capture_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o && claim_id == '0) |=> (claim_id != '0));

    p_claim_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (claim_id != '0 && !cmp_match) |=> $stable(claim_id));

    p_claim_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        32'(claim_id) < NUM_SRC);

    p_complete_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmp_match && claim_id != '0) |=> (claim_id == '0));

    p_idle_rdata_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> (rdata_o == 32'd0));
endmodule

bind ext_irq_ctrl eic_checker #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .ID_W(ID_W)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .src_i    (src_i),
    .addr_i   (addr_i),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .irq_o    (irq_o),
    .pend     (pend_w),
    .en       (en_w),
    .claim_id (claim_id_w)
);

// File: tb/sim_ext_irq_ctrl.sv
`timescale 1ns/1ps
module sim_ext_irq_ctrl;
    localparam int NSRC = 80;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src_v = '0;
    logic [9:0]      addr = '0;
    logic            wr_en = 1'b0, rd_en = 1'b0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic            irq;

    always #4 clk = ~clk;   // 125 MHz

    ext_irq_ctrl u0 (
        .clk_i(clk), .rst_ni(rst_n), .src_i(src_v), .addr_i(addr),
        .wr_en_i(wr_en), .wdata_i(wdata), .rd_en_i(rd_en),
        .rdata_o(rdata), .irq_o(irq)
    );

    int    n_chk = 0, n_bad = 0;
    string cur = "R11";

    // behavioural reference state
    bit m_pend [NSRC];
    bit m_en   [NSRC];
    int m_prio [NSRC];
    int m_thr = 0, m_claim = 0;
    logic        exp_irq = 1'b0;
    logic [31:0] exp_rd = '0;

    function automatic bit m_elig(int n);
        return n > 0 && m_pend[n] && m_en[n] && m_prio[n] > m_thr;
    endfunction

    function automatic logic [31:0] m_read(int a);
        int w;
        logic [31:0] r;
        w = a / 4;
        r = '0;
        if (a % 4 != 0) return '0;
        if (w < 3) begin
            for (int b = 0; b < 32; b++)
                if (w*32 + b < NSRC && m_pend[w*32+b]) r = r | (32'd1 << b);
        end else if (w >= 6 && w < 6 + NSRC) begin
            r = 32'(m_prio[w-6]);
        end else if (w >= 128 && w < 131) begin
            for (int b = 0; b < 32; b++)
                if ((w-128)*32 + b < NSRC && m_en[(w-128)*32+b]) r = r | (32'd1 << b);
        end else if (w == 131) begin
            r = 32'(m_thr);
        end else if (w == 132) begin
            r = 32'(m_claim);
        end
        return r;
    endfunction

    task automatic check(string what, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", cur, what, got, exp);
        end
    endtask

    task automatic cyc(bit wr, bit rd, int a, logic [31:0] d);
        int sel, oc, w;
        addr  = 10'(a);
        wr_en = wr;
        rd_en = rd;
        wdata = d;
        @(posedge clk);
        exp_rd = rd ? m_read(a) : 32'd0;
        w   = a / 4;
        sel = 0;
        for (int n = NSRC - 1; n >= 1; n--) if (m_elig(n)) sel = n;
        oc = m_claim;
        if (m_claim == 0) m_claim = sel;
        else if (wr && a == 'h210 && d == 32'(m_claim)) m_claim = 0;
        if (rd && a == 'h210) m_pend[oc] = 1'b0;
        for (int n = 1; n < NSRC; n++)
            if (((src_v >> n) & 80'd1) != 80'd0) m_pend[n] = 1'b1;
        if (wr && a % 4 == 0) begin
            if (w >= 6 && w < 6 + NSRC && w - 5 < NSRC) m_prio[w-5] = int'(d & 32'd7);
            if (w >= 128 && w < 131)
                for (int b = 0; b < 32; b++)
                    if ((w-128)*32 + b < NSRC)
                        m_en[(w-128)*32+b] = ((d >> b) & 32'd1) != 32'd0;
            if (w == 131) m_thr = int'(d & 32'd3);
        end
        exp_irq = 1'b0;
        for (int n = 1; n < NSRC; n++) if (m_elig(n)) exp_irq = 1'b1;
        @(negedge clk);
        check("irq_o", 32'(irq), 32'(exp_irq));
        check("rdata_o", rdata, exp_rd);
        wr_en = 1'b0;
        rd_en = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 0, 32'd0);
    endtask
    task automatic rd(int a);
        cyc(1'b0, 1'b1, a, 32'd0);
        idle(1);
    endtask
    task automatic wr(int a, logic [31:0] d);
        cyc(1'b1, 1'b0, a, d);
    endtask

    initial begin
        for (int n = 0; n < NSRC; n++) begin
            m_pend[n] = 1'b0; m_en[n] = 1'b0; m_prio[n] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cur = "R11 reset";
        check("irq_o", 32'(irq), 32'd0);
        check("rdata_o", rdata, 32'd0);
        rd('h000); rd('h210); rd('h20C); rd('h018 + 4*5); rd('h204);

        cur = "R3 priority";
        wr('h018 + 4*4, 32'hFF);       // source 5 <- 7
        rd('h018 + 4*5); rd('h018 + 4*4);
        wr('h018 + 4*79, 32'h5);       // no target
        rd('h018 + 4*79);
        wr('h018, 32'h6);              // source 1 <- 6
        rd('h018 + 4*1); rd('h018);
        wr('h018 + 4*7, 32'h3);        // source 8 <- 3
        wr('h018 + 4*39, 32'h4);       // source 40 <- 4
        wr('h018 + 4*69, 32'h4);       // source 70 <- 4

        cur = "R4 enable";
        wr('h208, 32'hFFFF_FFFF); rd('h208);
        wr('h200, 32'h0000_0122);      // sources 1, 5, 8
        wr('h204, 32'h0000_0100);      // source 40
        rd('h200); rd('h204);

        cur = "R5 threshold";
        wr('h20C, 32'hFF); rd('h20C);

        cur = "R6 priority not above threshold";
        src_v = '0; src_v[8] = 1'b1; idle(1); src_v = '0;
        idle(2); rd('h000); rd('h210);
        cur = "R6 threshold lowered";
        wr('h20C, 32'h2); idle(2);

        cur = "R8 claim read clears pending";
        rd('h210); rd('h000);
        cur = "R9 mismatched complete ignored";
        wr('h210, 32'd5); rd('h210);
        wr('h210, 32'h108); rd('h210);
        cur = "R9 matching complete";
        wr('h210, 32'd8); idle(1); rd('h210);

        cur = "R7 lowest eligible first";
        src_v = '0; src_v[5] = 1'b1; src_v[40] = 1'b1; src_v[70] = 1'b1;
        idle(1); src_v = '0; idle(2);
        rd('h210); rd('h000); wr('h210, 32'd5); idle(2);
        cur = "R7 held claim not replaced";
        src_v[1] = 1'b1; idle(1); src_v = '0; idle(2);
        rd('h210);
        wr('h210, 32'd40); idle(2);
        rd('h210); wr('h210, 32'd1); idle(2);
        rd('h210); wr('h210, 32'd70); idle(2); rd('h210);

        cur = "R1 source held through claim read";
        src_v[5] = 1'b1; idle(2);
        rd('h210); rd('h000);
        src_v = '0; wr('h210, 32'd5); idle(2);
        rd('h210); rd('h000); wr('h210, 32'd5); idle(2);
        cur = "R1 source zero";
        src_v[0] = 1'b1; wr('h200, 32'h1); idle(2); src_v = '0;
        rd('h000); rd('h210);

        cur = "R2 read-only and mode words";
        wr('h000, 32'hFFFF_FFFF); wr('h004, 32'hFFFF_FFFF);
        rd('h000); rd('h004);
        wr('h00C, 32'hFFFF_FFFF); rd('h00C); rd('h014);

        cur = "R10 unmapped and misaligned";
        wr('h300, 32'hFFFF_FFFF); rd('h300); rd('h3FC);
        wr('h20E, 32'h1); rd('h20C); rd('h20D);
        wr('h01A, 32'h7); rd('h018 + 4*2);

        idle(4);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL %s watchdog: got timeout expected completion", cur);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule